// File: doc/BRIEF.md
# Key-Protected Shutdown and Wake Controller

This block drives the power-down request of a small system. Software reaches it through a simple 32-bit word bus with four registers. One is a command register. One holds the alarm wake enables. One holds the per-pin wake enables and levels. The last is a status word that records why the system woke. A command write with bit 0 set asserts a latched `shutdownOut` toward the supply, but only when the write carries the password byte. Any write without the password leaves the output alone.

While `shutdownOut` is asserted, the block watches its wake sources. There are sixteen wake pins, each enabled on its own and each with its own active level, plus a real-time-clock alarm and a real-time-timer alarm. The first cycle in which any enabled source is active releases the output at the next clock edge. The same edge records every source that was active and enabled in that cycle. After power returns, software reads the status word to learn the cause, and the read clears it. The inputs are taken as already debounced and synchronous to `clk`, which is the slow always-on clock.

Top module: `shutdown_wake_ctrl`

## Requirements
- R1: After reset, `shutdownOut` is 0 and all four registers read 0. A zero status word means a plain power-on.
- R2: A write to offset 0x00 with bit 0 set and bits 31:24 equal to 0xA5 makes `shutdownOut` 1 from the next clock edge. It stays 1 until a wake or a reset.
- R3: A write to offset 0x00 with any other key byte, or with bit 0 clear, leaves `shutdownOut` unchanged. Offset 0x00 always reads 0.
- R4: The register at offset 0x04 stores bit 17 (RTC alarm wake enable) and bit 16 (RTT alarm wake enable). It reads back these bits with all other bits 0.
- R5: The register at offset 0x0C stores bits 15:0 as the per-pin wake enables. It stores bits 31:16 as the per-pin active levels, where 1 means active-high and 0 means active-low. It reads back as written.
- R6: While `shutdownOut` is 1, an enabled source at its active level drives `shutdownOut` to 0 at the next clock edge.
- R7: At that edge, the status word at offset 0x08 gets bit 5 for an RTC alarm, bit 4 for an RTT alarm, and bit 16+i for wake pin i. Only enabled sources are recorded. All sources active in the same cycle are recorded together.
- R8: Disabled sources neither release `shutdownOut` nor set status bits. With both offset 0x04 and offset 0x0C at zero, no source can wake the system.
- R9: A read of offset 0x08 returns the status word and clears it. If a wake is captured in the same cycle as the read, the read returns the old word and only the new bits remain afterwards.
- R10: Wake sources that are active while `shutdownOut` is 0 set no status bits. Writes to offset 0x08 have no effect.
- R11: Reset deasserts `shutdownOut` and clears all registers, even while a shutdown is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow always-on clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busSel | input | 1 | Bus access strobe, one cycle per access |
| busWrite | input | 1 | 1 for write, 0 for read |
| busAddr | input | ADDR_W | Byte address; bits 3:2 pick the register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, registered one cycle after the read strobe |
| wakePins | input | NUM_WAKE | Debounced wake pins |
| rtcAlarm | input | 1 | RTC alarm event |
| rttAlarm | input | 1 | RTT alarm event |
| shutdownOut | output | 1 | Latched power-down request to the supply |

## Verification
Two things can happen on the same clock edge: a wake capture into the status word, and a read that clears that word. The bench provokes this by holding a status word from an earlier RTC wake, then shutting down again and issuing the status read in the same cycle that the RTT alarm fires. It then checks three things: the read returns only the old RTC bit, the output is released, and a second read returns only the RTT bit. A second collision is also driven: an RTC, an RTT and a pin wake arrive in one cycle, and the bench checks that all three flags appear in a single status word.

// File: rtl/swc_pkg.sv
package swc_pkg;
  localparam int DATA_W = 32;

  localparam logic [1:0] IDX_CTRL = 2'd0;
  localparam logic [1:0] IDX_MODE = 2'd1;
  localparam logic [1:0] IDX_STAT = 2'd2;
  localparam logic [1:0] IDX_CFG  = 2'd3;

  localparam logic [7:0] SHUT_KEY = 8'hA5;
  localparam int KEY_LSB      = 24;
  localparam int SHUT_BIT     = 0;
  localparam int RTC_EN_BIT   = 17;
  localparam int RTT_EN_BIT   = 16;
  localparam int RTC_FLAG_BIT = 5;
  localparam int RTT_FLAG_BIT = 4;
  localparam int PIN_FLAG_LSB = 16;
  localparam int PIN_EN_LSB   = 0;
  localparam int POL_LSB      = 16;

  typedef struct packed {
    logic       shutReq;
    logic       wrMode;
    logic       wrCfg;
    logic       rdEn;
    logic       rdClr;
    logic [1:0] rdIdx;
  } swc_strobe_t;
endpackage

// File: rtl/swc_regctl.sv
module swc_regctl
  import swc_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output swc_strobe_t       strobe
);
  logic [1:0] regIdx;
  logic       keyOk;
  logic       isWrite;
  logic       isRead;
  logic       unusedBits;

  assign regIdx  = busAddr[3:2];
  assign keyOk   = (busWdata[KEY_LSB +: 8] == SHUT_KEY);
  assign isWrite = busSel & busWrite;
  assign isRead  = busSel & ~busWrite;
  assign unusedBits = ^{busAddr, busWdata};

  always_comb begin
    strobe         = '0;
    strobe.rdIdx   = regIdx;
    strobe.rdEn    = isRead;
    strobe.rdClr   = isRead  && (regIdx == IDX_STAT);
    strobe.wrMode  = isWrite && (regIdx == IDX_MODE);
    strobe.wrCfg   = isWrite && (regIdx == IDX_CFG);
    strobe.shutReq = isWrite && (regIdx == IDX_CTRL) && keyOk && busWdata[SHUT_BIT];
  end
endmodule

// File: rtl/swc_datapath.sv
module swc_datapath
  import swc_pkg::*;
#(
  parameter int NUM_WAKE = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  swc_strobe_t         strobe,
  input  logic [DATA_W-1:0]   wdata,
  input  logic [NUM_WAKE-1:0] wakePins,
  input  logic                rtcAlarm,
  input  logic                rttAlarm,
  output logic                shutdownOut,
  output logic [DATA_W-1:0]   rdata,
  output logic                modeRtcEn,
  output logic                modeRttEn,
  output logic [NUM_WAKE-1:0] wakeEn,
  output logic [NUM_WAKE-1:0] wakePol,
  output logic [DATA_W-1:0]   statusWord
);
  logic [NUM_WAKE-1:0] pinHit;
  logic [NUM_WAKE-1:0] pinFlags;
  logic                rtcFlag;
  logic                rttFlag;
  logic                rtcHit;
  logic                rttHit;
  logic                anyHit;
  logic                capture;
  logic                shutQ;
  logic [DATA_W-1:0]   modeWord;
  logic [DATA_W-1:0]   cfgWord;
  logic [DATA_W-1:0]   rdataQ;
  logic [DATA_W-1:0]   rdMux;

  for (genvar i = 0; i < NUM_WAKE; i++) begin : g_pin
    assign pinHit[i] = wakeEn[i] & (wakePins[i] == wakePol[i]);
  end

  assign rtcHit  = modeRtcEn & rtcAlarm;
  assign rttHit  = modeRttEn & rttAlarm;
  assign anyHit  = (|pinHit) | rtcHit | rttHit;
  assign capture = shutQ & anyHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shutQ <= 1'b0;
    end else if (capture) begin
      shutQ <= 1'b0;
    end else if (strobe.shutReq) begin
      shutQ <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeRtcEn <= 1'b0;
      modeRttEn <= 1'b0;
    end else if (strobe.wrMode) begin
      modeRtcEn <= wdata[RTC_EN_BIT];
      modeRttEn <= wdata[RTT_EN_BIT];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wakeEn  <= '0;
      wakePol <= '0;
    end else if (strobe.wrCfg) begin
      wakeEn  <= wdata[PIN_EN_LSB +: NUM_WAKE];
      wakePol <= wdata[POL_LSB +: NUM_WAKE];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pinFlags <= '0;
      rtcFlag  <= 1'b0;
      rttFlag  <= 1'b0;
    end else if (capture) begin
      pinFlags <= (strobe.rdClr ? '0 : pinFlags) | pinHit;
      rtcFlag  <= (strobe.rdClr ? 1'b0 : rtcFlag) | rtcHit;
      rttFlag  <= (strobe.rdClr ? 1'b0 : rttFlag) | rttHit;
    end else if (strobe.rdClr) begin
      pinFlags <= '0;
      rtcFlag  <= 1'b0;
      rttFlag  <= 1'b0;
    end
  end

  always_comb begin
    statusWord = '0;
    statusWord[PIN_FLAG_LSB +: NUM_WAKE] = pinFlags;
    statusWord[RTC_FLAG_BIT] = rtcFlag;
    statusWord[RTT_FLAG_BIT] = rttFlag;

    modeWord = '0;
    modeWord[RTC_EN_BIT] = modeRtcEn;
    modeWord[RTT_EN_BIT] = modeRttEn;

    cfgWord = '0;
    cfgWord[PIN_EN_LSB +: NUM_WAKE] = wakeEn;
    cfgWord[POL_LSB +: NUM_WAKE]    = wakePol;

    unique case (strobe.rdIdx)
      IDX_MODE: rdMux = modeWord;
      IDX_STAT: rdMux = statusWord;
      IDX_CFG:  rdMux = cfgWord;
      default:  rdMux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdataQ <= '0;
    end else if (strobe.rdEn) begin
      rdataQ <= rdMux;
    end
  end

  assign shutdownOut = shutQ;
  assign rdata       = rdataQ;
endmodule

// File: rtl/shutdown_wake_ctrl.sv
module shutdown_wake_ctrl
  import swc_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int NUM_WAKE = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                busSel,
  input  logic                busWrite,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [31:0]         busWdata,
  output logic [31:0]         busRdata,
  input  logic [NUM_WAKE-1:0] wakePins,
  input  logic                rtcAlarm,
  input  logic                rttAlarm,
  output logic                shutdownOut
);
  swc_strobe_t         strobe;
  logic                modeRtcEn;
  logic                modeRttEn;
  logic [NUM_WAKE-1:0] wakeEn;
  logic [NUM_WAKE-1:0] wakePol;
  logic [DATA_W-1:0]   statusWord;

  swc_regctl #(.ADDR_W(ADDR_W)) i_regctl (
    .busSel   (busSel),
    .busWrite (busWrite),
    .busAddr  (busAddr),
    .busWdata (busWdata),
    .strobe   (strobe)
  );

  swc_datapath #(.NUM_WAKE(NUM_WAKE)) i_datapath (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .wdata       (busWdata),
    .wakePins    (wakePins),
    .rtcAlarm    (rtcAlarm),
    .rttAlarm    (rttAlarm),
    .shutdownOut (shutdownOut),
    .rdata       (busRdata),
    .modeRtcEn   (modeRtcEn),
    .modeRttEn   (modeRttEn),
    .wakeEn      (wakeEn),
    .wakePol     (wakePol),
    .statusWord  (statusWord)
  );
endmodule

// File: rtl/swc_checker.sv
module swc_checker #(
  parameter int ADDR_W   = 4,
  parameter int NUM_WAKE = 16
) (
  input logic                clk,
  input logic                rstN,
  input logic                busSel,
  input logic                busWrite,
  input logic [ADDR_W-1:0]   busAddr,
  input logic [31:0]         busWdata,
  input logic                rtcAlarm,
  input logic                rttAlarm,
  input logic                shutdownOut,
  input logic                modeRtcEn,
  input logic [NUM_WAKE-1:0] wakeEn,
  input logic [31:0]         statusWord
);
  logic goodCmd;
  logic statRead;
  assign goodCmd  = busSel && busWrite && (busAddr[3:2] == 2'd0) &&
                    (busWdata[31:24] == 8'hA5) && busWdata[0];
  assign statRead = busSel && !busWrite && (busAddr[3:2] == 2'd2);

  // R2
  assert_key_shut_R2: assert property (@(posedge clk) disable iff (!rstN)
    (goodCmd && !shutdownOut) |=> shutdownOut);

  // R3
  assert_no_key_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!goodCmd && !shutdownOut) |=> !shutdownOut);

  // R6
  assert_rtc_release_R6: assert property (@(posedge clk) disable iff (!rstN)
    (shutdownOut && rtcAlarm && modeRtcEn) |=> !shutdownOut);

  // R8
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (shutdownOut && !rtcAlarm && !rttAlarm && (wakeEn == '0)) |=> shutdownOut);

  // R7
  assert_rtc_flag_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusWord[5]) |-> ($past(rtcAlarm) && $past(shutdownOut)));

  // R9
  assert_read_clear_R9: assert property (@(posedge clk) disable iff (!rstN)
    (statRead && !shutdownOut) |=> (statusWord == 32'h0));
endmodule

bind shutdown_wake_ctrl swc_checker #(.ADDR_W(ADDR_W), .NUM_WAKE(NUM_WAKE)) i_chk (
  .clk         (clk),
  .rstN        (rstN),
  .busSel      (busSel),
  .busWrite    (busWrite),
  .busAddr     (busAddr),
  .busWdata    (busWdata),
  .rtcAlarm    (rtcAlarm),
  .rttAlarm    (rttAlarm),
  .shutdownOut (shutdownOut),
  .modeRtcEn   (modeRtcEn),
  .wakeEn      (wakeEn),
  .statusWord  (statusWord)
);

// File: tb/test_shutdown_wake_ctrl.sv
`timescale 1ns/1ps
module test_shutdown_wake_ctrl;
  localparam int NW = 16;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          busSel = 1'b0;
  logic          busWrite = 1'b0;
  logic [3:0]    busAddr = '0;
  logic [31:0]   busWdata = '0;
  logic [31:0]   busRdata;
  logic [NW-1:0] wakePins = '0;
  logic          rtcAlarm = 1'b0;
  logic          rttAlarm = 1'b0;
  logic          shutdownOut;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  shutdown_wake_ctrl #(.ADDR_W(4), .NUM_WAKE(NW)) i_shutdown_wake_ctrl (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .wakePins(wakePins), .rtcAlarm(rtcAlarm), .rttAlarm(rttAlarm),
    .shutdownOut(shutdownOut)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWr(input logic [3:0] a, input logic [31:0] d);
    busSel = 1'b1; busWrite = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWrite = 1'b0; busWdata = '0;
  endtask

  task automatic busRd(input logic [3:0] a, output logic [31:0] d);
    busSel = 1'b1; busWrite = 1'b0; busAddr = a;
    @(negedge clk);
    busSel = 1'b0;
    d = busRdata;
  endtask

  task automatic doReset();
    rstN = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] rd;
    doReset();

    // R1 reset state
    chk("R1 shutdownOut", {31'b0, shutdownOut}, 32'h0);
    busRd(4'h0, rd); chk("R1 ctrl", rd, 32'h0);
    busRd(4'h4, rd); chk("R1 mode", rd, 32'h0);
    busRd(4'h8, rd); chk("R1 status", rd, 32'h0);
    busRd(4'hC, rd); chk("R1 cfg", rd, 32'h0);

    // R4 / R5 readback
    busWr(4'h4, 32'hFFFF_FFFF); busRd(4'h4, rd); chk("R4 mode mask", rd, 32'h0003_0000);
    busWr(4'h4, 32'h0002_0000); busRd(4'h4, rd); chk("R4 rtc only", rd, 32'h0002_0000);
    busWr(4'hC, 32'hDEAD_BEEF); busRd(4'hC, rd); chk("R5 cfg", rd, 32'hDEAD_BEEF);
    // R10 status write ignored, R3 ctrl reads zero
    busWr(4'h8, 32'hFFFF_FFFF); busRd(4'h8, rd); chk("R10 status write", rd, 32'h0);
    busRd(4'h0, rd); chk("R3 ctrl read", rd, 32'h0);

    // R3 key sweep
    busWr(4'h4, 32'h0); busWr(4'hC, 32'h0);
    for (int k = 0; k < 256; k++) begin
      if (k != 8'hA5) begin
        busWr(4'h0, {k[7:0], 24'h1});
        chk("R3 bad key", {31'b0, shutdownOut}, 32'h0);
      end
    end
    busWr(4'h0, 32'hA500_0000); chk("R3 bit0 clear", {31'b0, shutdownOut}, 32'h0);
    busWr(4'h0, 32'hA500_0001); chk("R2 good key", {31'b0, shutdownOut}, 32'h1);
    busWr(4'h0, 32'h1200_0001); chk("R2 holds", {31'b0, shutdownOut}, 32'h1);
    busWr(4'h4, 32'h0002_0000);
    rtcAlarm = 1'b1; @(negedge clk);
    chk("R6 rtc release", {31'b0, shutdownOut}, 32'h0);
    rtcAlarm = 1'b0;
    busRd(4'h8, rd); chk("R7 rtc flag", rd, 32'h0000_0020);
    busRd(4'h8, rd); chk("R9 cleared", rd, 32'h0);

    // R6/R7 pin sweep, both levels
    busWr(4'h4, 32'h0);
    for (int p = 0; p < 2; p++) begin
      for (int i = 0; i < NW; i++) begin
        busWr(4'hC, (32'(p) << (16 + i)) | (32'h1 << i));
        wakePins = (p == 1) ? '0 : '1;
        busWr(4'h0, 32'hA500_0001);
        chk("R2 pin shut", {31'b0, shutdownOut}, 32'h1);
        wakePins[i] = (p == 1);
        @(negedge clk);
        chk("R6 pin release", {31'b0, shutdownOut}, 32'h0);
        wakePins = (p == 1) ? '0 : '1;
        busRd(4'h8, rd); chk("R7 pin flag", rd, 32'h1 << (16 + i));
        busRd(4'h8, rd); chk("R9 pin clear", rd, 32'h0);
      end
    end
    wakePins = '0;

    // R8 disabled source ignored
    busWr(4'hC, 32'h0); busWr(4'h4, 32'h0002_0000);
    busWr(4'h0, 32'hA500_0001);
    rttAlarm = 1'b1; @(negedge clk);
    chk("R8 rtt disabled", {31'b0, shutdownOut}, 32'h1);
    rttAlarm = 1'b0;
    busRd(4'h8, rd); chk("R8 no flag", rd, 32'h0);
    rtcAlarm = 1'b1; @(negedge clk); rtcAlarm = 1'b0;
    chk("R6 rtc", {31'b0, shutdownOut}, 32'h0);
    busRd(4'h8, rd); chk("R7 rtc only", rd, 32'h0000_0020);

    // R7 simultaneous sources
    busWr(4'h4, 32'h0003_0000); busWr(4'hC, 32'h0008_0008);
    busWr(4'h0, 32'hA500_0001);
    rtcAlarm = 1'b1; rttAlarm = 1'b1; wakePins[3] = 1'b1;
    @(negedge clk);
    rtcAlarm = 1'b0; rttAlarm = 1'b0; wakePins = '0;
    chk("R6 multi release", {31'b0, shutdownOut}, 32'h0);
    busRd(4'h8, rd); chk("R7 multi flags", rd, 32'h0008_0030);

    // R9 read-clear colliding with capture
    busWr(4'hC, 32'h0);
    busWr(4'h0, 32'hA500_0001);
    rtcAlarm = 1'b1; @(negedge clk); rtcAlarm = 1'b0;
    busWr(4'h0, 32'hA500_0001);
    chk("R2 reshut", {31'b0, shutdownOut}, 32'h1);
    busSel = 1'b1; busWrite = 1'b0; busAddr = 4'h8; rttAlarm = 1'b1;
    @(negedge clk);
    busSel = 1'b0; rttAlarm = 1'b0;
    chk("R9 old word", busRdata, 32'h0000_0020);
    chk("R6 collide release", {31'b0, shutdownOut}, 32'h0);
    busRd(4'h8, rd); chk("R9 new bit kept", rd, 32'h0000_0010);
    busRd(4'h8, rd); chk("R9 empty", rd, 32'h0);

    // R10 wake while running ignored
    rtcAlarm = 1'b1; rttAlarm = 1'b1; @(negedge clk);
    rtcAlarm = 1'b0; rttAlarm = 1'b0;
    busRd(4'h8, rd); chk("R10 running wake", rd, 32'h0);

    // R8 everything disabled, R11 reset releases
    busWr(4'h4, 32'h0); busWr(4'hC, 32'h0);
    busWr(4'h0, 32'hA500_0001);
    rtcAlarm = 1'b1; rttAlarm = 1'b1; wakePins = '1; @(negedge clk);
    chk("R8 all disabled high", {31'b0, shutdownOut}, 32'h1);
    wakePins = '0; @(negedge clk);
    chk("R8 all disabled low", {31'b0, shutdownOut}, 32'h1);
    rtcAlarm = 1'b0; rttAlarm = 1'b0;
    busRd(4'h8, rd); chk("R8 status empty", rd, 32'h0);
    busWr(4'h4, 32'h0003_0000);
    doReset();
    chk("R11 reset release", {31'b0, shutdownOut}, 32'h0);
    busRd(4'h4, rd); chk("R11 mode cleared", rd, 32'h0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule